// File: doc/BRIEF.md
# Framed Serial DAC Command Receiver

This block is the digital front end of a serially programmed DAC. A host writes 16-bit commands over three wires: an active-low frame strobe, a serial clock and a data line. The three wires are brought into the system clock domain. On each falling edge of the serial clock inside a frame, one bit is shifted in, most significant bit first. The sixteenth bit completes the command. That command then loads a 12-bit DAC code and a 2-bit power mode at once, and a one-cycle update pulse marks the load.

Once a command has run, the receiver locks. Serial clock edges are then ignored until the strobe has gone high and fallen again. If the strobe rises before all sixteen bits have arrived, the partial command is dropped. The outputs feed the resistor-string converter and its output stage, which sit outside this block. The system clock must run at least four times as fast as the serial clock.

Top module: `sdac_cmd_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first completed command, dac_code_o is 0, pwr_mode_o is 00 and update_o is 0.
- R2: While the strobe is low, each falling serial clock edge shifts in one data bit, most significant bit first. After 16 bits, dac_code_o holds command bits [11:0].
- R3: pwr_mode_o takes command bits [13:12]. The encodings are 00 normal operation, 01 output pulled low through 1 kΩ, 10 output pulled low through 100 kΩ and 11 high impedance. Bits [15:14] have no effect.
- R4: The command executes after the 16th falling serial clock edge without waiting for the strobe to rise. The outputs change no later than 4 system clock cycles after that edge reaches the pins.
- R5: update_o is high for exactly one system clock cycle per completed command. dac_code_o and pwr_mode_o change only in a cycle where update_o is high.
- R6: After a command completes, further serial clock edges are ignored while the strobe stays low. Only a rise and a new fall of the strobe start the next command.
- R7: If the strobe rises before the 16th bit, the partial command is discarded. The outputs keep their values, no update pulse occurs, and the next frame counts from its first bit.
- R8: A strobe that is already low when reset is released does not open a frame. Only a falling edge of the strobe does.
- R9: Serial clock edges while the strobe is high shift nothing and do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | Active-low frame strobe, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, bits taken on its falling edge |
| sdin_i | input | 1 | Serial data, most significant bit first |
| dac_code_o | output | 12 | Registered DAC code |
| pwr_mode_o | output | 2 | Registered power mode |
| update_o | output | 1 | One-cycle pulse when a command is applied |

## Verification
The bench builds the block with its defaults: a 16-bit frame, a 12-bit code and two synchronizer stages. With these values the three-cycle input latency and the full mode field lie in reach of short directed frames. The serial clock is driven at eight system cycles per bit, which is twice the minimum ratio, so every bit crosses the synchronizers cleanly. This setup reaches the main cases: commands that execute while the strobe is still low, the lock after completion, truncated frames, clock activity outside a frame, a strobe held low through reset, and a reset in the middle of a frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_ACTIVE   = 2'b00,
    PM_PULL_1K  = 2'b01,
    PM_PULL_100K = 2'b10,
    PM_HIZ      = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    FS_IDLE   = 2'b00,
    FS_SHIFT  = 2'b01,
    FS_LOCKED = 2'b10
  } frame_st_e;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q[0] <= '0;
    end else begin
      stage_q[0] <= async_i;
    end
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sdac_fall_det.sv
module sdac_fall_det #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb begin
    prev_d = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~lvl_i;

endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned KEEP_BITS  = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe_hi_i,
  input  logic                 strobe_fall_i,
  input  logic                 sclk_fall_i,
  input  logic                 din_i,
  output logic [KEEP_BITS-1:0] word_o,
  output logic                 done_o
);

  localparam int unsigned CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  frame_st_e              st_q, st_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [KEEP_BITS-2:0]   sh_q, sh_d;
  logic                   sh_en;
  logic                   cnt_en;
  logic                   done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_en  = 1'b0;
    cnt_en = 1'b0;
    done_d = 1'b0;
    if (strobe_fall_i) begin
      st_d   = FS_SHIFT;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (st_q)
        FS_IDLE: begin
          st_d = FS_IDLE;
        end
        FS_SHIFT: begin
          if (strobe_hi_i) begin
            st_d   = FS_IDLE;
            cnt_d  = '0;
            cnt_en = 1'b1;
          end else if (sclk_fall_i) begin
            sh_en  = 1'b1;
            cnt_en = 1'b1;
            if (cnt_q == LAST_IDX) begin
              done_d = 1'b1;
              st_d   = FS_LOCKED;
              cnt_d  = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        FS_LOCKED: begin
          if (strobe_hi_i) begin
            st_d = FS_IDLE;
          end
        end
        default: begin
          st_d = FS_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    sh_d = sh_q;
    if (sh_en) begin
      sh_d = {sh_q[KEEP_BITS-3:0], din_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  assign word_o = {sh_q, din_i};
  assign done_o = done_d;

endmodule

// File: rtl/sdac_cmd_regs.sv
module sdac_cmd_regs
  import sdac_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [CODE_W+MODE_W-1:0] word_i,
  output logic [CODE_W-1:0]        code_o,
  output pwr_mode_e                mode_o,
  output logic                     update_o
);

  logic [CODE_W-1:0] code_q, code_d;
  pwr_mode_e         mode_q, mode_d;
  logic              upd_q, upd_d;

  always_comb begin
    code_d = word_i[CODE_W-1:0];
    mode_d = pwr_mode_e'(word_i[CODE_W+MODE_W-1:CODE_W]);
    upd_d  = load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= PM_ACTIVE;
    end else if (load_i) begin
      code_q <= code_d;
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
    end
  end

  assign code_o   = code_q;
  assign mode_o   = mode_q;
  assign update_o = upd_q;

endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
  import sdac_pkg::*;
#(
  parameter int unsigned FRAME_BITS  = 16,
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n_i,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [1:0]        pwr_mode_o,
  output logic              update_o
);

  localparam int unsigned KEEP_BITS = CODE_W + MODE_W;
  localparam int unsigned IDX_FRM   = 0;
  localparam int unsigned IDX_SCK   = 1;
  localparam int unsigned IDX_DIN   = 2;

  logic [2:0]           pins_s;
  logic [1:0]           fall;
  logic [KEEP_BITS-1:0] frame_word;
  logic                 frame_done;
  logic                 frame_lvl;
  pwr_mode_e            mode_reg;

  sdac_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sdin_i, sclk_i, frame_n_i}),
    .sync_o  (pins_s)
  );

  sdac_fall_det #(
    .WIDTH (2)
  ) u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  ({pins_s[IDX_SCK], pins_s[IDX_FRM]}),
    .fall_o (fall)
  );

  assign frame_lvl = pins_s[IDX_FRM];

  sdac_frame_rx #(
    .FRAME_BITS (FRAME_BITS),
    .KEEP_BITS  (KEEP_BITS)
  ) u_frame (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe_hi_i   (frame_lvl),
    .strobe_fall_i (fall[0]),
    .sclk_fall_i   (fall[1]),
    .din_i         (pins_s[IDX_DIN]),
    .word_o        (frame_word),
    .done_o        (frame_done)
  );

  sdac_cmd_regs #(
    .CODE_W (CODE_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (frame_done),
    .word_i   (frame_word),
    .code_o   (dac_code_o),
    .mode_o   (mode_reg),
    .update_o (update_o)
  );

  assign pwr_mode_o = mode_reg;

endmodule

// File: rtl/sdac_cmd_rx_chk.sv
module sdac_cmd_rx_chk #(
  parameter int unsigned CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] dac_code_o,
  input logic [1:0]        pwr_mode_o,
  input logic              update_o,
  input logic              frame_done,
  input logic              frame_lvl
);

  // R1: outputs sit at their reset values while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_vals_r1: assert (dac_code_o == '0 && pwr_mode_o == 2'b00 && !update_o)
        else $error("reset values wrong");
    end
  end

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o);

  p_code_needs_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code_o != $past(dac_code_o)) |-> update_o);

  p_mode_needs_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode_o != $past(pwr_mode_o)) |-> update_o);

  p_done_to_upd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> update_o);

  p_no_done_strobe_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lvl |-> !frame_done);

endmodule

bind sdac_cmd_rx sdac_cmd_rx_chk #(
  .CODE_W (CODE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dac_code_o (dac_code_o),
  .pwr_mode_o (pwr_mode_o),
  .update_o   (update_o),
  .frame_done (frame_done),
  .frame_lvl  (frame_lvl)
);

// File: tb/sdac_cmd_rx_test.sv
module sdac_cmd_rx_test;

  localparam int CLK_P = 10;
  localparam int HALF_BIT = 4;
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0ABC, 16'h1FFF, 16'h2001, 16'h3800, 16'hC555, 16'hF123
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n_i;
  logic        sclk_i;
  logic        sdin_i;
  logic [11:0] dac_code_o;
  logic [1:0]  pwr_mode_o;
  logic        update_o;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int wide = 0;
  int stray = 0;
  bit prev_upd = 1'b0;
  logic [13:0] last_out = '0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sdac_cmd_rx uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n_i  (frame_n_i),
    .sclk_i     (sclk_i),
    .sdin_i     (sdin_i),
    .dac_code_o (dac_code_o),
    .pwr_mode_o (pwr_mode_o),
    .update_o   (update_o)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_upd <= 1'b0;
      last_out <= '0;
    end else begin
      if (update_o) pulses <= pulses + 1;
      if (update_o && prev_upd) wide <= wide + 1;
      if ({pwr_mode_o, dac_code_o} != last_out && !update_o) stray <= stray + 1;
      prev_upd <= update_o;
      last_out <= {pwr_mode_o, dac_code_o};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sclk_i = 1'b1;
    sdin_i = b;
    wait_cyc(HALF_BIT);
    sclk_i = 1'b0;
    wait_cyc(HALF_BIT);
  endtask

  task automatic open_frame();
    frame_n_i = 1'b1;
    sclk_i = 1'b1;
    wait_cyc(HALF_BIT);
    frame_n_i = 1'b0;
    wait_cyc(HALF_BIT);
  endtask

  task automatic close_frame();
    sclk_i = 1'b1;
    sdin_i = 1'b0;
    wait_cyc(HALF_BIT);
    frame_n_i = 1'b1;
    wait_cyc(HALF_BIT);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n);
    for (int i = 15; i > 15 - n; i--) bit_out(w[i]);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    rst_n = 1'b0;
    frame_n_i = 1'b0;
    sclk_i = 1'b1;
    sdin_i = 1'b0;
    wait_cyc(5);
    chk("R1 code in reset", 32'(dac_code_o), 32'h0);
    chk("R1 mode in reset", 32'(pwr_mode_o), 32'h0);
    chk("R1 update in reset", 32'(update_o), 32'h0);
    rst_n = 1'b1;
    wait_cyc(6);
    chk("R1 code after release", 32'(dac_code_o), 32'h0);

    // R8: strobe low since reset, no fresh fall
    p0 = pulses;
    shift_bits(16'h1ABC, 16);
    wait_cyc(6);
    chk("R8 no frame without strobe fall", 32'(pulses - p0), 32'h0);
    chk("R8 code unchanged", 32'(dac_code_o), 32'h0);
    close_frame();

    // table of commands: R2 R3 R4
    for (int v = 0; v < NVEC; v++) begin
      p0 = pulses;
      open_frame();
      shift_bits(VEC[v], 16);
      wait_cyc(4);
      chk("R4 pulse with strobe low", 32'(pulses - p0), 32'h1);
      chk("R2 code", 32'(dac_code_o), 32'(VEC[v][11:0]));
      chk("R3 mode", 32'(pwr_mode_o), 32'(VEC[v][13:12]));
      close_frame();
    end

    // R7: truncated frame
    p0 = pulses;
    open_frame();
    shift_bits(16'h2777, 10);
    close_frame();
    wait_cyc(6);
    chk("R7 no pulse on partial", 32'(pulses - p0), 32'h0);
    chk("R7 code kept", 32'(dac_code_o), 32'h123);
    chk("R7 mode kept", 32'(pwr_mode_o), 32'h3);
    open_frame();
    shift_bits(16'h0123, 16);
    wait_cyc(4);
    chk("R7 next frame counts from start", 32'({pwr_mode_o, dac_code_o}), 32'h0123);
    close_frame();

    // R6: lock after completion
    open_frame();
    shift_bits(16'h1456, 16);
    wait_cyc(4);
    p0 = pulses;
    shift_bits(16'h0999, 16);
    wait_cyc(6);
    chk("R6 extra edges no pulse", 32'(pulses - p0), 32'h0);
    chk("R6 outputs held", 32'({pwr_mode_o, dac_code_o}), 32'h1456);
    close_frame();
    open_frame();
    shift_bits(16'h0999, 16);
    wait_cyc(4);
    chk("R6 new frame after strobe cycle", 32'({pwr_mode_o, dac_code_o}), 32'h0999);
    close_frame();

    // R9: clocks with strobe high
    p0 = pulses;
    frame_n_i = 1'b1;
    shift_bits(16'hFFFF, 16);
    sclk_i = 1'b1;
    wait_cyc(6);
    chk("R9 no pulse strobe high", 32'(pulses - p0), 32'h0);
    chk("R9 outputs held", 32'({pwr_mode_o, dac_code_o}), 32'h0999);
    open_frame();
    shift_bits(16'h0042, 16);
    wait_cyc(4);
    chk("R9 next frame clean", 32'({pwr_mode_o, dac_code_o}), 32'h0042);
    close_frame();

    // R1: reset in mid-frame
    open_frame();
    shift_bits(16'h3ABC, 8);
    rst_n = 1'b0;
    wait_cyc(3);
    chk("R1 code after mid reset", 32'({pwr_mode_o, dac_code_o}), 32'h0);
    rst_n = 1'b1;
    shift_bits(16'h3ABC, 16);
    wait_cyc(6);
    chk("R8 strobe low across reset", 32'({pwr_mode_o, dac_code_o}), 32'h0);
    close_frame();
    open_frame();
    shift_bits(16'h2DEF, 16);
    wait_cyc(4);
    chk("R3 mode after recovery", 32'(pwr_mode_o), 32'h2);
    close_frame();

    chk("R5 pulse width one cycle", 32'(wide), 32'h0);
    chk("R5 no change without pulse", 32'(stray), 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule